// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small CPU core and turns raw interrupt sources into a single request line plus the information the core needs to fetch a handler address. It takes one active-low reset request and four maskable sources: three external lines and one timer underflow pulse. Every maskable source is latched into a pending flag. A fixed priority picks one winner, and the block presents a registered request, the winner's level number and the two byte addresses of its vector.

Vectors for all levels live in one table that grows downward from the top of a 16-bit address space, two bytes per level. A separate lookup port returns the same kind of address pair for software trap numbers 0 to 23. The core pulses an acknowledge while the request is up. That clears only the flag of the level being shown, and the core drops its global enable, which holds off further maskable requests until software raises it again for nesting.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `irq` is 0, `irq_code` is 0, `vec_msb`/`vec_lsb` read FFFE/FFFF, and with `trap_num` at 0 `trap_msb`/`trap_lsb` read FFFE/FFFF.
- R2: An external line whose `trig_edge` bit is 1 sets its flag on a rising edge seen through a two-flop synchronizer. A rise driven before clock edge k raises `irq` after edge k+3. Holding the line high does not set the flag again. `ext_req` bit 0 feeds level 1, bit 1 feeds level 3, bit 2 feeds level 4.
- R3: An external line whose `trig_edge` bit is 0 sets its flag on every cycle its synchronized value is high. An acknowledge while the line is still high leaves the flag set.
- R4: A one-cycle `tmr_zero` pulse before edge k sets the level 2 flag without synchronization, and `irq` rises after edge k+1.
- R5: The priority from highest to lowest is level 0 (reset request), then levels 1, 2, 3 and 4. `irq_code` carries the winning level number as a 3-bit value.
- R6: Whenever `irq` is 1, `vec_msb` equals FFFE minus twice `irq_code` and `vec_lsb` equals `vec_msb` plus 1.
- R7: `ack` high before an edge forces `irq` to 0 after that edge. It clears only the flag of the level shown in `irq_code`, and other pending levels are presented afterwards.
- R8: With `gie` low, no maskable level raises `irq`. Pending flags survive and are presented the cycle after `gie` returns high.
- R9: A flag whose `src_en` bit (bit i for level i+1) is low stays pending without raising `irq`. It is presented the cycle after the enable is set.
- R10: A low `rst_req_n` is level-sensitive and ignores `gie` and `src_en`. It raises `irq` with code 0 after the third edge from the fall. An acknowledge does not clear it. `irq` drops after the third edge from release.
- R11: If an edge-mode rising edge would set a flag on the same edge that an acknowledge clears it, the flag stays set and is presented again.
- R12: `trap_msb` is FFFE minus twice `trap_num`, and `trap_lsb` is that value plus 1. Both are registered one cycle. Values above 23 select trap 23 (FFD0/FFD1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_n | input | 1 | Active-low, level-sensitive reset request (level 0) |
| ext_req | input | 3 | Raw external lines for levels 1, 3, 4 (bits 0, 1, 2) |
| tmr_zero | input | 1 | Timer underflow pulse for level 2 |
| src_en | input | 4 | Per-level enables, bit i for level i+1 |
| trig_edge | input | 3 | Per external line: 1 rising edge, 0 level |
| gie | input | 1 | CPU global interrupt enable |
| ack | input | 1 | CPU acknowledge strobe |
| trap_num | input | 5 | Software trap number for the lookup port |
| irq | output | 1 | Registered interrupt request |
| irq_code | output | 3 | Winning level number |
| vec_msb | output | 16 | Address of the vector high byte |
| vec_lsb | output | 16 | Address of the vector low byte |
| trap_msb | output | 16 | Trap vector high-byte address |
| trap_lsb | output | 16 | Trap vector low-byte address |

## Verification
The bench stacks several pending levels behind a low global enable and retires them one acknowledge at a time. A controller that cleared every flag on acknowledge would go idle early, and one with a wrong priority order would show the wrong codes. It places a fresh edge exactly on the acknowledge edge, where a design with clear beating set would lose the interrupt. It also holds a level-mode line high through an acknowledge, where a design ignoring the set term would fall silent. The reset request is driven with the enable low and is then acknowledged, which catches a level 0 that is maskable or that can be cleared. A sweep of trap numbers past 23 exposes a lookup that wraps instead of saturating.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int LVL_NUM = 5;
  localparam int N_MASK  = LVL_NUM - 1;
  localparam int CODE_W  = $clog2(LVL_NUM);
  localparam int ADDR_W  = 16;

  typedef logic [CODE_W-1:0] lvl_code_t;
  typedef logic [ADDR_W-1:0] vaddr_t;

  localparam vaddr_t VEC_TOP = 16'hFFFE;

  typedef struct packed {
    logic      valid;
    lvl_code_t code;
  } pick_t;
endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqv_src_flag.sv
module irqv_src_flag #(
  parameter bit IS_EXT      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);
  logic set;

  generate
    if (IS_EXT) begin : g_ext
      logic sync_q, prev_q;
      irqv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
        .clk(clk), .rst(rst), .d(raw), .q(sync_q)
      );
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q;
      end
      assign set = edge_mode ? (sync_q & ~prev_q) : sync_q;
    end else begin : g_int
      logic unused_mode;
      assign unused_mode = edge_mode;
      assign set = raw;
    end
  endgenerate

  // a new event in the clearing cycle wins over the clear
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set | (flag & ~clr);
  end

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (set && clr) |=> flag); // R11
endmodule

// File: rtl/irqv_prio_arb.sv
module irqv_prio_arb
  import irqv_pkg::*;
(
  input  logic              rst_pend,
  input  logic [N_MASK-1:0] req,
  output pick_t             pick
);
  always_comb begin
    pick.valid = 1'b0;
    pick.code  = '0;
    // walk from lowest priority up so the highest one is left standing
    for (int i = N_MASK - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick.valid = 1'b1;
        pick.code  = lvl_code_t'(i + 1);
      end
    end
    if (rst_pend) begin
      pick.valid = 1'b1;
      pick.code  = '0;
    end
  end
endmodule

// File: rtl/irqv_vec_calc.sv
module irqv_vec_calc
  import irqv_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int MAX_IDX = 23
) (
  input  logic [IDX_W-1:0] idx,
  output vaddr_t           msb,
  output vaddr_t           lsb
);
  logic [IDX_W-1:0] sat;
  vaddr_t           off;

  always_comb begin
    sat = (idx > IDX_W'(MAX_IDX)) ? IDX_W'(MAX_IDX) : idx;
    off = vaddr_t'(sat) << 1;
    msb = VEC_TOP - off;
    lsb = msb + vaddr_t'(1);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TRAPS   = 24,
  parameter int TRAP_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_req_n,
  input  logic [2:0]        ext_req,
  input  logic              tmr_zero,
  input  logic [N_MASK-1:0] src_en,
  input  logic [2:0]        trig_edge,
  input  logic              gie,
  input  logic              ack,
  input  logic [TRAP_W-1:0] trap_num,
  output logic              irq,
  output logic [CODE_W-1:0] irq_code,
  output logic [ADDR_W-1:0] vec_msb,
  output logic [ADDR_W-1:0] vec_lsb,
  output logic [ADDR_W-1:0] trap_msb,
  output logic [ADDR_W-1:0] trap_lsb
);
  localparam int TIMER_IDX = 1;

  logic              rst_req_s, rst_pend;
  logic [N_MASK-1:0] raw_src, mode_src, clr_src, flags, req;
  pick_t             pick;
  logic              irq_nxt;
  vaddr_t            lvl_msb, lvl_lsb, trp_msb, trp_lsb;

  irqv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rst_sync (
    .clk(clk), .rst(rst), .d(rst_req_n), .q(rst_req_s)
  );
  assign rst_pend = ~rst_req_s;

  // level i+1 sources: ext0, timer, ext1, ext2
  assign raw_src  = {ext_req[2], ext_req[1], tmr_zero, ext_req[0]};
  assign mode_src = {trig_edge[2], trig_edge[1], 1'b1, trig_edge[0]};

  generate
    for (genvar i = 0; i < N_MASK; i++) begin : g_src
      assign clr_src[i] = ack & irq & (irq_code == lvl_code_t'(i + 1));
      irqv_src_flag #(.IS_EXT(i != TIMER_IDX), .SYNC_STAGES(SYNC_STAGES)) i_flag (
        .clk(clk), .rst(rst), .raw(raw_src[i]), .edge_mode(mode_src[i]),
        .clr(clr_src[i]), .flag(flags[i])
      );
    end
  endgenerate

  assign req = flags & src_en & {N_MASK{gie}};

  irqv_prio_arb i_arb (.rst_pend(rst_pend), .req(req), .pick(pick));

  irqv_vec_calc #(.IDX_W(CODE_W), .MAX_IDX(LVL_NUM - 1)) i_lvl_vec (
    .idx(pick.code), .msb(lvl_msb), .lsb(lvl_lsb)
  );
  irqv_vec_calc #(.IDX_W(TRAP_W), .MAX_IDX(NUM_TRAPS - 1)) i_trap_vec (
    .idx(trap_num), .msb(trp_msb), .lsb(trp_lsb)
  );

  assign irq_nxt = pick.valid & ~ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      irq_code <= '0;
      vec_msb  <= VEC_TOP;
      vec_lsb  <= VEC_TOP + vaddr_t'(1);
      trap_msb <= VEC_TOP;
      trap_lsb <= VEC_TOP + vaddr_t'(1);
    end else begin
      irq      <= irq_nxt;
      trap_msb <= trp_msb;
      trap_lsb <= trp_lsb;
      if (irq_nxt) begin
        irq_code <= pick.code;
        vec_msb  <= lvl_msb;
        vec_lsb  <= lvl_lsb;
      end
    end
  end

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq); // R7
  AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!gie && !rst_pend) |=> !irq); // R8
  AST_RST_NONMASK: assert property (@(posedge clk) disable iff (rst)
    (rst_pend && !ack) |=> (irq && irq_code == '0)); // R10
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (int'(irq_code) < LVL_NUM)); // R5
  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq |-> (vec_msb == VEC_TOP - (vaddr_t'(irq_code) << 1))); // R6
  AST_TRAP_PAIR: assert property (@(posedge clk) disable iff (rst)
    trap_lsb == trap_msb + vaddr_t'(1)); // R12
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/100ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_req_n = 1'b1;
  logic [2:0]  ext_req = '0;
  logic        tmr_zero = 1'b0;
  logic [3:0]  src_en = 4'hF;
  logic [2:0]  trig_edge = 3'b111;
  logic        gie = 1'b1;
  logic        ack = 1'b0;
  logic [4:0]  trap_num = '0;
  logic        irq;
  logic [2:0]  irq_code;
  logic [15:0] vec_msb, vec_lsb, trap_msb, trap_lsb;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .rst_req_n(rst_req_n), .ext_req(ext_req),
    .tmr_zero(tmr_zero), .src_en(src_en), .trig_edge(trig_edge), .gie(gie),
    .ack(ack), .trap_num(trap_num), .irq(irq), .irq_code(irq_code),
    .vec_msb(vec_msb), .vec_lsb(vec_lsb), .trap_msb(trap_msb), .trap_lsb(trap_lsb)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int       at;
    logic     irq;
    logic [2:0] code;
    string    tag;
  } exp_t;
  exp_t sbq[$];

  function automatic logic [15:0] vtop(int n);
    return 16'hFFFE - 16'(2 * n);
  endfunction

  task automatic check(bit ok, string tag, string got, string want);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %s expected %s (cycle %0d)", tag, got, want, cyc);
    end
  endtask

  // driver side: push an expectation d cycles ahead, kept in time order
  task automatic expect_at(int d, logic i, logic [2:0] c, string tag);
    exp_t e;
    int pos;
    e.at = cyc + d; e.irq = i; e.code = c; e.tag = tag;
    pos = sbq.size();
    while (pos > 0 && sbq[pos-1].at > e.at) pos--;
    sbq.insert(pos, e);
  endtask

  // monitor side
  always @(negedge clk) begin
    exp_t e;
    bit ok;
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      e = sbq.pop_front();
      ok = (e.at == cyc) && (irq === e.irq);
      if (e.irq)
        ok = ok && (irq_code === e.code) && (vec_msb === vtop(int'(e.code)))
             && (vec_lsb === vtop(int'(e.code)) + 16'd1);
      check(ok, e.tag,
            $sformatf("irq=%0b code=%0d vec=%h/%h", irq, irq_code, vec_msb, vec_lsb),
            $sformatf("irq=%0b code=%0d vec=%h/%h", e.irq, e.code,
                      vtop(int'(e.code)), vtop(int'(e.code)) + 16'd1));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(string tag);
    ack = 1'b1; gie = 1'b0;
    expect_at(1, 1'b0, 3'd0, tag);
    tick(1);
    ack = 1'b0; gie = 1'b1;
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(irq === 1'b0 && irq_code === 3'd0 && vec_msb === 16'hFFFE && vec_lsb === 16'hFFFF
          && trap_msb === 16'hFFFE && trap_lsb === 16'hFFFF, "R1",
          $sformatf("%0b %0d %h %h %h %h", irq, irq_code, vec_msb, vec_lsb, trap_msb, trap_lsb),
          "0 0 fffe ffff fffe ffff");
    tick(2);

    // R4 timer pulse, then R7 acknowledge leaves nothing behind
    tmr_zero = 1'b1;
    expect_at(2, 1'b1, 3'd2, "R4");
    tick(1); tmr_zero = 1'b0; tick(1);
    do_ack("R7");
    expect_at(1, 1'b0, 3'd0, "R7");
    expect_at(3, 1'b0, 3'd0, "R7");
    tick(4);

    // R2/R5 two edges at once; R7 only the shown level is cleared
    ext_req = 3'b101;
    expect_at(4, 1'b1, 3'd1, "R5");
    tick(4);
    do_ack("R7");
    expect_at(1, 1'b1, 3'd4, "R7");
    tick(1);
    do_ack("R7");
    expect_at(1, 1'b0, 3'd0, "R2");
    ext_req = 3'b000;
    tick(5);

    // R8/R5 three levels stacked behind a low enable
    gie = 1'b0; ext_req = 3'b110; tmr_zero = 1'b1;
    expect_at(5, 1'b0, 3'd0, "R8");
    tick(1); tmr_zero = 1'b0; tick(5);
    gie = 1'b1;
    expect_at(1, 1'b1, 3'd2, "R5");
    tick(1);
    do_ack("R5");
    expect_at(1, 1'b1, 3'd3, "R5");
    tick(1);
    do_ack("R5");
    expect_at(1, 1'b1, 3'd4, "R5");
    tick(1);
    do_ack("R5");
    ext_req = 3'b000;
    expect_at(1, 1'b0, 3'd0, "R7");
    expect_at(3, 1'b0, 3'd0, "R7");
    tick(5);

    // R9 disabled source stays pending
    src_en = 4'b1011;
    ext_req = 3'b010;
    expect_at(4, 1'b0, 3'd0, "R9");
    expect_at(6, 1'b0, 3'd0, "R9");
    tick(7);
    src_en = 4'hF;
    expect_at(1, 1'b1, 3'd3, "R9");
    tick(1);
    do_ack("R9");
    expect_at(1, 1'b0, 3'd0, "R9");
    ext_req = 3'b000;
    tick(5);

    // R3 level mode survives an acknowledge while high
    trig_edge = 3'b110;
    ext_req = 3'b001;
    expect_at(4, 1'b1, 3'd1, "R3");
    tick(4);
    do_ack("R3");
    expect_at(1, 1'b1, 3'd1, "R3");
    tick(1);
    ext_req = 3'b000;
    tick(2);
    do_ack("R3");
    expect_at(1, 1'b0, 3'd0, "R3");
    expect_at(3, 1'b0, 3'd0, "R3");
    tick(5);
    trig_edge = 3'b111;
    tick(2);

    // R11 fresh edge lands on the acknowledge edge
    ext_req = 3'b001;
    expect_at(4, 1'b1, 3'd1, "R2");
    tick(1); ext_req = 3'b000;
    tick(1); ext_req = 3'b001;
    tick(2);
    do_ack("R11");
    expect_at(1, 1'b1, 3'd1, "R11");
    tick(1);
    do_ack("R11");
    expect_at(1, 1'b0, 3'd0, "R11");
    ext_req = 3'b000;
    tick(5);

    // R10 reset request: non-maskable, not cleared by ack, level 4 waits
    gie = 1'b0; ext_req = 3'b100;
    expect_at(4, 1'b0, 3'd0, "R8");
    tick(5);
    src_en = 4'h0;
    rst_req_n = 1'b0;
    expect_at(3, 1'b1, 3'd0, "R10");
    tick(3);
    ack = 1'b1;
    expect_at(1, 1'b0, 3'd0, "R10");
    tick(1);
    ack = 1'b0;
    expect_at(1, 1'b1, 3'd0, "R10");
    tick(1);
    src_en = 4'hF;
    rst_req_n = 1'b1;
    expect_at(2, 1'b1, 3'd0, "R10");
    expect_at(3, 1'b0, 3'd0, "R10");
    tick(3);
    gie = 1'b1;
    expect_at(1, 1'b1, 3'd4, "R8");
    tick(1);
    do_ack("R8");
    expect_at(1, 1'b0, 3'd0, "R8");
    ext_req = 3'b000;
    tick(5);

    // R12 trap lookup sweep including out-of-range numbers
    for (int n = 0; n < 32; n++) begin
      int m;
      m = (n > 23) ? 23 : n;
      trap_num = 5'(n);
      tick(1);
      check(trap_msb === vtop(m) && trap_lsb === vtop(m) + 16'd1, "R12",
            $sformatf("%h/%h", trap_msb, trap_lsb),
            $sformatf("%h/%h", vtop(m), vtop(m) + 16'd1));
    end

    tick(3);
    check(sbq.size() == 0, "SCOREBOARD", $sformatf("%0d left", sbq.size()), "0 left");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end

  initial begin
    #250000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end
endmodule